// File: doc/BRIEF.md
# Byte Access Bridge with I/O Page Decode

This block sits after address translation. It takes one physical access at a time and routes it to one of two targets: a main memory that only moves whole words, or a peripheral bus that can read words and write single bytes but cannot read a single byte. A fixed 8 KiB window at the top of the active address space is the I/O page. Where that window starts depends on two mode inputs: relocation enable and wide (22-bit) addressing. Any access at or above the window start goes to the peripheral bus, carrying only the offset inside the page. Every other access goes to memory with the full address.

Byte reads are always served by a word read at the even address, and the wanted byte is extracted little-endian. Byte writes to memory become a read, merge, write sequence. Byte writes to the peripheral bus are passed through as native byte writes. A word access to an odd address is refused: the block reports an address error and starts no bus cycle.

Both targets use a valid/ready handshake. Each request ends with a one-cycle done pulse that carries the read data and the error flag.

Top module: `iopage_byte_bridge`

## Requirements
- R1: The I/O page starts at octal 160000 when `reloc_en` is 0, whatever `wide_en` is. It starts at octal 760000 when `reloc_en` is 1 and `wide_en` is 0, and at octal 17760000 when both are 1.
- R2: A request whose address is at or above the page start uses only the peripheral bus, with `io_addr` set to address bits [12:0]. A request below the page start uses only memory, with `mem_addr` set to the full address (bit 0 cleared).
- R3: A byte read issues exactly one word read (`io_byte`=0) at the address with bit 0 cleared. The result is zero-extended into `rsp_rdata`: bits [15:8] of the fetched word for an odd address, bits [7:0] for an even one.
- R4: A byte write to memory issues a word read at the even address, then one idle cycle, then a word write to the same address. The written word has the addressed byte replaced by `req_wdata[7:0]` and the other byte kept from the read.
- R5: A byte write to the I/O page issues a single peripheral write with `io_byte`=1. `io_addr` keeps bit 0 of the address, and `req_wdata[7:0]` is placed in both halves of `io_wdata`.
- R6: A word access issues one cycle on its target at the unchanged address. A write passes `req_wdata` unchanged, and a read returns the whole fetched word in `rsp_rdata`.
- R7: A word access (`req_byte`=0) to an odd address raises `rsp_addr_err` together with `rsp_done` in the cycle after acceptance, and starts no cycle on either bus.
- R8: At most one of `mem_valid`/`io_valid` is high at any time. A valid stays high with its address, data, write and byte fields stable until the matching ready. `req_ready` is low while a request is in progress.
- R9: `rsp_done` is a single-cycle pulse, one cycle after the last target handshake of the request. `rsp_rdata` and `rsp_addr_err` are valid during that pulse, and `rsp_addr_err` is never high without `rsp_done`.
- R10: After reset the block is idle: `req_ready` high, both bus valids low, `rsp_done` low, `rsp_rdata` zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reloc_en | input | 1 | Relocation mode, moves the I/O page to the 18-bit top |
| wide_en | input | 1 | Wide addressing mode, with reloc_en moves the page to the 22-bit top |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 22 | Physical byte address |
| req_byte | input | 1 | 1 = byte access, 0 = word access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data (byte writes use bits [7:0]) |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_addr_err | output | 1 | Odd word address refused, valid with rsp_done |
| rsp_rdata | output | 16 | Read result, valid with rsp_done |
| mem_valid | output | 1 | Memory cycle request |
| mem_ready | input | 1 | Memory cycle completes |
| mem_write | output | 1 | Memory write |
| mem_addr | output | 22 | Memory word address (bit 0 zero) |
| mem_wdata | output | 16 | Memory write word |
| mem_rdata | input | 16 | Memory read word, valid with mem_ready |
| io_valid | output | 1 | Peripheral cycle request |
| io_ready | input | 1 | Peripheral cycle completes |
| io_write | output | 1 | Peripheral write |
| io_byte | output | 1 | Peripheral byte write |
| io_addr | output | 13 | Offset inside the I/O page |
| io_wdata | output | 16 | Peripheral write data |
| io_rdata | input | 16 | Peripheral read word, valid with io_ready |

## Verification
The bench probes both sides of each page start in all three mode combinations. It also checks the pair reloc off with wide on, where a design that honoured the wide bit alone would send octal 160002 to memory. Odd-address byte writes to memory check the merge lane and the read-then-write order: a swapped lane corrupts the neighbouring byte, and a skipped read replaces the kept byte with stale data. The same odd byte writes toward the page must show up as one native byte cycle with bit 0 intact, not a read-modify-write. Odd word addresses must produce the error pulse with no cycle on either bus.

// File: rtl/ibb_pkg.sv
package ibb_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_FETCH = 2'd1,
    SEQ_MERGE = 2'd2,
    SEQ_STORE = 2'd3
  } seq_state_e;

  // Start of a page of 2**offs_w bytes sitting at the top of a 2**space_w space.
  function automatic logic [63:0] page_base(input int unsigned space_w, input int unsigned offs_w);
    return (64'd1 << space_w) - (64'd1 << offs_w);
  endfunction

  // Little-endian byte extraction from a word.
  function automatic logic [BYTE_W-1:0] pick_byte(input logic [WORD_W-1:0] w, input logic odd);
    return odd ? w[WORD_W-1:BYTE_W] : w[BYTE_W-1:0];
  endfunction

  // Replace one byte lane of a word.
  function automatic logic [WORD_W-1:0] merge_byte(input logic [WORD_W-1:0] w,
                                                   input logic [BYTE_W-1:0] b,
                                                   input logic odd);
    logic [WORD_W-1:0] r;
    r = w;
    if (odd) r[WORD_W-1:BYTE_W] = b;
    else     r[BYTE_W-1:0]      = b;
    return r;
  endfunction
endpackage

// File: rtl/ibb_page_decode.sv
module ibb_page_decode #(
  parameter int unsigned PA_W      = 22,
  parameter int unsigned IO_OFFS_W = 13,
  parameter int unsigned NARROW_W  = 16,
  parameter int unsigned MID_W     = 18
) (
  input  logic [PA_W-1:0]      addr,
  input  logic                 reloc_en,
  input  logic                 wide_en,
  output logic                 hit_io,
  output logic [IO_OFFS_W-1:0] io_offs
);
  localparam logic [PA_W-1:0] BASE_NARROW = PA_W'(ibb_pkg::page_base(NARROW_W, IO_OFFS_W));
  localparam logic [PA_W-1:0] BASE_MID    = PA_W'(ibb_pkg::page_base(MID_W, IO_OFFS_W));
  localparam logic [PA_W-1:0] BASE_WIDE   = PA_W'(ibb_pkg::page_base(PA_W, IO_OFFS_W));

  logic [PA_W-1:0] base;

  always_comb begin
    if (!reloc_en)     base = BASE_NARROW;
    else if (!wide_en) base = BASE_MID;
    else               base = BASE_WIDE;
    hit_io  = (addr >= base);
    io_offs = addr[IO_OFFS_W-1:0];
  end
endmodule

// File: rtl/ibb_lane.sv
module ibb_lane
  import ibb_pkg::*;
(
  input  logic [WORD_W-1:0] fetched,
  input  logic              odd,
  input  logic [BYTE_W-1:0] fresh,
  output logic [WORD_W-1:0] picked,
  output logic [WORD_W-1:0] merged,
  output logic [WORD_W-1:0] spread
);
  localparam int unsigned LANES = WORD_W / BYTE_W;

  always_comb begin
    picked = WORD_W'(pick_byte(fetched, odd));
    merged = merge_byte(fetched, fresh, odd);
  end

  for (genvar g = 0; g < LANES; g++) begin : g_spread
    assign spread[g*BYTE_W +: BYTE_W] = fresh;
  end
endmodule

// File: rtl/ibb_seq.sv
module ibb_seq
  import ibb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic acc_err,
  input  logic acc_write,
  input  logic acc_rmw,
  input  logic tgt_ready,
  output logic in_idle,
  output logic in_fetch,
  output logic in_merge,
  output logic in_store,
  output logic rmw_q,
  output logic finish
);
  seq_state_e st, st_nx;
  logic       rmw_nx;

  always_comb begin
    st_nx  = st;
    rmw_nx = rmw_q;
    finish = 1'b0;
    unique case (st)
      SEQ_IDLE: begin
        if (accept) begin
          rmw_nx = acc_rmw;
          if (acc_err)                    finish = 1'b1;
          else if (acc_write && !acc_rmw) st_nx  = SEQ_STORE;
          else                            st_nx  = SEQ_FETCH;
        end
      end
      SEQ_FETCH: begin
        if (tgt_ready) begin
          if (rmw_q) st_nx = SEQ_MERGE;
          else begin
            st_nx  = SEQ_IDLE;
            finish = 1'b1;
          end
        end
      end
      SEQ_MERGE: st_nx = SEQ_STORE;
      SEQ_STORE: begin
        if (tgt_ready) begin
          st_nx  = SEQ_IDLE;
          finish = 1'b1;
        end
      end
      default: st_nx = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= SEQ_IDLE;
      rmw_q <= 1'b0;
    end else begin
      st    <= st_nx;
      rmw_q <= rmw_nx;
    end
  end

  assign in_idle  = (st == SEQ_IDLE);
  assign in_fetch = (st == SEQ_FETCH);
  assign in_merge = (st == SEQ_MERGE);
  assign in_store = (st == SEQ_STORE);
endmodule

// File: rtl/iopage_byte_bridge.sv
module iopage_byte_bridge
  import ibb_pkg::*;
#(
  parameter int unsigned PA_W      = 22,
  parameter int unsigned IO_OFFS_W = 13
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reloc_en,
  input  logic                 wide_en,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [PA_W-1:0]      req_addr,
  input  logic                 req_byte,
  input  logic                 req_write,
  input  logic [WORD_W-1:0]    req_wdata,
  output logic                 rsp_done,
  output logic                 rsp_addr_err,
  output logic [WORD_W-1:0]    rsp_rdata,
  output logic                 mem_valid,
  input  logic                 mem_ready,
  output logic                 mem_write,
  output logic [PA_W-1:0]      mem_addr,
  output logic [WORD_W-1:0]    mem_wdata,
  input  logic [WORD_W-1:0]    mem_rdata,
  output logic                 io_valid,
  input  logic                 io_ready,
  output logic                 io_write,
  output logic                 io_byte,
  output logic [IO_OFFS_W-1:0] io_addr,
  output logic [WORD_W-1:0]    io_wdata,
  input  logic [WORD_W-1:0]    io_rdata
);
  // Decode of the live request
  logic                 hit_io;
  logic [IO_OFFS_W-1:0] io_offs;
  logic                 accept;
  logic                 odd_word;
  logic                 acc_rmw;

  // Latched request
  logic [PA_W-1:0]      q_addr;
  logic                 q_byte;
  logic                 q_io;
  logic [IO_OFFS_W-1:0] q_offs;
  logic [BYTE_W-1:0]    q_bdata;
  logic [WORD_W-1:0]    wbuf;

  // Sequencer events, named for the checker
  logic in_idle, in_fetch, in_merge, in_store, rmw_q, finish;
  logic tgt_ready;
  logic [WORD_W-1:0] tgt_rdata;
  logic rmw_fetch;
  logic fetch_done;

  // Lane results
  logic [WORD_W-1:0] lane_in, lane_pick, lane_merge, lane_spread;

  ibb_page_decode #(.PA_W(PA_W), .IO_OFFS_W(IO_OFFS_W)) u_decode (
    .addr     (req_addr),
    .reloc_en (reloc_en),
    .wide_en  (wide_en),
    .hit_io   (hit_io),
    .io_offs  (io_offs)
  );

  assign req_ready = in_idle && !rsp_done;
  assign accept    = req_valid && req_ready;
  assign odd_word  = !req_byte && req_addr[0];
  assign acc_rmw   = req_byte && req_write && !hit_io;

  ibb_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .acc_err   (odd_word),
    .acc_write (req_write),
    .acc_rmw   (acc_rmw),
    .tgt_ready (tgt_ready),
    .in_idle   (in_idle),
    .in_fetch  (in_fetch),
    .in_merge  (in_merge),
    .in_store  (in_store),
    .rmw_q     (rmw_q),
    .finish    (finish)
  );

  assign tgt_ready  = q_io ? io_ready : mem_ready;
  assign tgt_rdata  = q_io ? io_rdata : mem_rdata;
  assign rmw_fetch  = in_fetch && rmw_q;
  assign fetch_done = in_fetch && tgt_ready;

  assign lane_in = in_merge ? wbuf : tgt_rdata;

  ibb_lane u_lane (
    .fetched (lane_in),
    .odd     (q_addr[0]),
    .fresh   (q_bdata),
    .picked  (lane_pick),
    .merged  (lane_merge),
    .spread  (lane_spread)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_addr       <= '0;
      q_byte       <= 1'b0;
      q_io         <= 1'b0;
      q_offs       <= '0;
      q_bdata      <= '0;
      wbuf         <= '0;
      rsp_done     <= 1'b0;
      rsp_addr_err <= 1'b0;
      rsp_rdata    <= '0;
    end else begin
      rsp_done     <= finish;
      rsp_addr_err <= accept && odd_word;
      if (accept) begin
        q_addr  <= req_addr;
        q_byte  <= req_byte;
        q_io    <= hit_io;
        q_offs  <= io_offs;
        q_bdata <= req_wdata[BYTE_W-1:0];
        wbuf    <= req_wdata;
      end
      if (fetch_done) begin
        rsp_rdata <= q_byte ? lane_pick : tgt_rdata;
        if (rmw_q) wbuf <= tgt_rdata;
      end else if (finish) begin
        rsp_rdata <= '0;
      end
      if (in_merge) wbuf <= lane_merge;
    end
  end

  // Memory side: whole words only, always at the even address
  assign mem_valid = (in_fetch || in_store) && !q_io;
  assign mem_write = in_store;
  assign mem_addr  = {q_addr[PA_W-1:1], 1'b0};
  assign mem_wdata = wbuf;

  // Peripheral side: word reads, native byte writes
  assign io_valid = (in_fetch || in_store) && q_io;
  assign io_write = in_store;
  assign io_byte  = in_store && q_byte && q_io;
  assign io_addr  = io_byte ? q_offs : {q_offs[IO_OFFS_W-1:1], 1'b0};
  assign io_wdata = io_byte ? lane_spread : wbuf;
endmodule

// File: rtl/ibb_chk.sv
module ibb_chk #(
  parameter int unsigned PA_W      = 22,
  parameter int unsigned IO_OFFS_W = 13,
  parameter int unsigned DW        = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic                 req_ready,
  input logic                 req_byte,
  input logic [PA_W-1:0]      req_addr,
  input logic                 rsp_done,
  input logic                 rsp_addr_err,
  input logic                 mem_valid,
  input logic                 mem_ready,
  input logic                 mem_write,
  input logic [PA_W-1:0]      mem_addr,
  input logic [DW-1:0]        mem_wdata,
  input logic                 io_valid,
  input logic                 io_ready,
  input logic                 io_write,
  input logic                 io_byte,
  input logic [IO_OFFS_W-1:0] io_addr,
  input logic [DW-1:0]        io_wdata,
  input logic                 rmw_fetch
);
  a_r8_one_target: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_valid && io_valid));

  a_r8_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_write) && $stable(mem_wdata)));

  a_r8_io_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (io_valid && !io_ready) |=> (io_valid && $stable(io_addr) && $stable(io_wdata) && $stable(io_write) && $stable(io_byte)));

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  a_r9_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_addr_err |-> rsp_done);

  a_r7_odd_word: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_byte && req_addr[0]) |=> (rsp_done && rsp_addr_err && !mem_valid && !io_valid));

  a_r4_rmw_order: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready && rmw_fetch) |=> !mem_valid ##1 (mem_valid && mem_write && (mem_addr == $past(mem_addr, 2))));

  a_r3_even_mem: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> !mem_addr[0]);

  a_r5_io_word_even: assert property (@(posedge clk) disable iff (!rst_n)
    (io_valid && !io_byte) |-> !io_addr[0]);
endmodule

bind iopage_byte_bridge ibb_chk #(.PA_W(PA_W), .IO_OFFS_W(IO_OFFS_W), .DW(ibb_pkg::WORD_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_byte     (req_byte),
  .req_addr     (req_addr),
  .rsp_done     (rsp_done),
  .rsp_addr_err (rsp_addr_err),
  .mem_valid    (mem_valid),
  .mem_ready    (mem_ready),
  .mem_write    (mem_write),
  .mem_addr     (mem_addr),
  .mem_wdata    (mem_wdata),
  .io_valid     (io_valid),
  .io_ready     (io_ready),
  .io_write     (io_write),
  .io_byte      (io_byte),
  .io_addr      (io_addr),
  .io_wdata     (io_wdata),
  .rmw_fetch    (rmw_fetch)
);

// File: tb/iopage_byte_bridge_test.sv
`timescale 1ns/1ps
module iopage_byte_bridge_test;
  localparam int AW = 22;
  localparam int OW = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reloc_en = 1'b0, wide_en = 1'b0;
  logic req_valid = 1'b0, req_byte = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic req_ready, rsp_done, rsp_addr_err;
  logic [15:0] rsp_rdata;
  logic mem_valid, mem_write;
  logic mem_ready = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic io_valid, io_write, io_byte;
  logic io_ready = 1'b0;
  logic [OW-1:0] io_addr;
  logic [15:0] io_wdata;
  logic [15:0] io_rdata = '0;

  int compared = 0;
  int mismatched = 0;
  int mem_lat = 0, io_lat = 0, mcnt = 0, icnt = 0;
  logic [15:0] memq [int];
  logic [15:0] iomq [int];
  logic [40:0] got_q [$];

  always #2 clk = ~clk;

  iopage_byte_bridge uut (
    .clk(clk), .rst_n(rst_n), .reloc_en(reloc_en), .wide_en(wide_en),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_byte(req_byte), .req_write(req_write), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_addr_err(rsp_addr_err), .rsp_rdata(rsp_rdata),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .io_valid(io_valid), .io_ready(io_ready), .io_write(io_write), .io_byte(io_byte),
    .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata)
  );

  function automatic logic [15:0] mem_peek(input int a);
    return memq.exists(a) ? memq[a] : 16'(a * 37 + 4951);
  endfunction

  function automatic logic [15:0] io_peek(input int a);
    return iomq.exists(a) ? iomq[a] : 16'(a * 11 + 40000);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [40:0] act, input logic [40:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Target models: ready after a latency, drop the cycle after a handshake
  always @(negedge clk) begin
    if (mem_ready) begin mem_ready = 1'b0; mcnt = 0; end
    else if (mem_valid) begin
      if (mcnt >= mem_lat) begin mem_ready = 1'b1; mem_rdata = mem_peek(int'(mem_addr)); end
      else mcnt++;
    end
    if (io_ready) begin io_ready = 1'b0; icnt = 0; end
    else if (io_valid) begin
      if (icnt >= io_lat) begin io_ready = 1'b1; io_rdata = io_peek(int'({io_addr[OW-1:1], 1'b0})); end
      else icnt++;
    end
  end

  // Transaction log and model storage update at the handshake edge
  always @(posedge clk) begin
    if (rst_n && mem_valid && mem_ready) begin
      got_q.push_back({1'b0, mem_write, 1'b0, mem_addr, mem_write ? mem_wdata : mem_rdata});
      if (mem_write) memq[int'(mem_addr)] = mem_wdata;
    end
    if (rst_n && io_valid && io_ready) begin
      got_q.push_back({1'b1, io_write, io_byte, AW'(io_addr), io_write ? io_wdata : io_rdata});
      if (io_write) begin
        int k;
        logic [15:0] w;
        k = int'({io_addr[OW-1:1], 1'b0});
        w = io_peek(k);
        if (!io_byte) w = io_wdata;
        else if (io_addr[0]) w[15:8] = io_wdata[15:8];
        else w[7:0] = io_wdata[7:0];
        iomq[k] = w;
      end
    end
  end

  // Per-clock comparison of bus exclusivity and error/done pairing
  always @(negedge clk) begin
    if (rst_n) begin
      chk(!(mem_valid && io_valid), "R8 both targets valid", {39'd0, mem_valid, io_valid}, 41'd0);
      chk(!(rsp_addr_err && !rsp_done), "R9 error without done", {40'd0, rsp_addr_err}, {40'd0, rsp_done});
    end
  end

  task automatic run_op(input logic [AW-1:0] a, input logic by, input logic wr,
                        input logic [15:0] wd, input logic rl, input logic w22, input string tag);
    logic [AW-1:0] base, ea, off, eoff;
    logic hit, err;
    logic [15:0] w, nw, exp_rd;
    logic [40:0] exp_q [$];
    int waited;
    base = !rl ? AW'(22'o160000) : (!w22 ? AW'(22'o760000) : AW'(22'o17760000));
    hit  = (a >= base);
    err  = !by && a[0];
    ea   = {a[AW-1:1], 1'b0};
    off  = {9'd0, a[OW-1:0]};
    eoff = {off[AW-1:1], 1'b0};
    exp_rd = '0;
    if (!err) begin
      w = hit ? io_peek(int'(eoff)) : mem_peek(int'(ea));
      if (!wr) begin
        exp_q.push_back({hit, 1'b0, 1'b0, hit ? eoff : ea, w});
        exp_rd = by ? (a[0] ? {8'h00, w[15:8]} : {8'h00, w[7:0]}) : w;
      end else if (hit) begin
        if (by) exp_q.push_back({1'b1, 1'b1, 1'b1, off, {wd[7:0], wd[7:0]}});
        else    exp_q.push_back({1'b1, 1'b1, 1'b0, off, wd});
      end else if (by) begin
        nw = w;
        if (a[0]) nw[15:8] = wd[7:0];
        else      nw[7:0]  = wd[7:0];
        exp_q.push_back({1'b0, 1'b0, 1'b0, ea, w});
        exp_q.push_back({1'b0, 1'b1, 1'b0, ea, nw});
      end else begin
        exp_q.push_back({1'b0, 1'b1, 1'b0, a, wd});
      end
    end
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    got_q.delete();
    reloc_en = rl; wide_en = w22;
    req_addr = a; req_byte = by; req_write = wr; req_wdata = wd; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    waited = 0;
    while (!rsp_done && waited < 100) begin @(negedge clk); waited++; end
    chk(rsp_done == 1'b1, {tag, " R9 done pulse"}, {40'd0, rsp_done}, 41'd1);
    chk(rsp_addr_err == err, {tag, " R7 error flag"}, {40'd0, rsp_addr_err}, {40'd0, err});
    if (!wr && !err)
      chk(rsp_rdata == exp_rd, {tag, " read data"}, {25'd0, rsp_rdata}, {25'd0, exp_rd});
    chk(got_q.size() == exp_q.size(), {tag, " R2 bus cycle count"}, 41'(got_q.size()), 41'(exp_q.size()));
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      chk(got_q[i] == exp_q[i], {tag, " bus cycle {io,wr,byte,addr,data}"}, got_q[i], exp_q[i]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    $display("FAIL watchdog expired before the test sequence finished");
    compared++;
    mismatched++;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R10 ready after reset", {40'd0, req_ready}, 41'd1);
    chk(!mem_valid && !io_valid, "R10 no bus valid after reset", {39'd0, mem_valid, io_valid}, 41'd0);
    chk(rsp_done == 1'b0 && rsp_rdata == 16'h0, "R10 response idle after reset", {24'd0, rsp_done, rsp_rdata}, 41'd0);

    // Memory word and byte traffic, zero latency
    run_op(22'o001000, 1'b0, 1'b1, 16'hBEEF, 1'b0, 1'b0, "R6 word write");
    run_op(22'o001000, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, "R6 word read");
    run_op(22'o001001, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b0, "R3 byte read odd");
    run_op(22'o001000, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b0, "R3 byte read even");
    run_op(22'o001001, 1'b1, 1'b1, 16'h775A, 1'b0, 1'b0, "R4 byte write odd");
    run_op(22'o001000, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, "R4 readback after odd");
    run_op(22'o002000, 1'b1, 1'b1, 16'h11C3, 1'b0, 1'b0, "R4 byte write even");
    run_op(22'o002000, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, "R4 readback after even");

    // Slower memory, page boundary with relocation off
    mem_lat = 3;
    run_op(22'o002003, 1'b1, 1'b1, 16'h00A5, 1'b0, 1'b0, "R4 byte write slow memory");
    run_op(22'o157777, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b0, "R1 R2 just below narrow page");
    run_op(22'o160000, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, "R1 R2 narrow page start");
    run_op(22'o160002, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b1, "R1 wide without relocation");

    // Relocation on, 18-bit page
    io_lat = 2;
    run_op(22'o160000, 1'b0, 1'b0, 16'h0000, 1'b1, 1'b0, "R1 R2 old page start is memory");
    run_op(22'o757776, 1'b0, 1'b0, 16'h0000, 1'b1, 1'b0, "R1 R2 below mid page");
    run_op(22'o760000, 1'b0, 1'b0, 16'h0000, 1'b1, 1'b0, "R1 R2 mid page start");
    run_op(22'o777777, 1'b1, 1'b0, 16'h0000, 1'b1, 1'b0, "R3 io byte read odd");

    // Relocation and wide addressing
    run_op(22'o760000, 1'b0, 1'b0, 16'h0000, 1'b1, 1'b1, "R1 R2 mid page start is memory when wide");
    run_op(22'o17757777, 1'b1, 1'b0, 16'h0000, 1'b1, 1'b1, "R1 R3 below wide page");
    run_op(22'o17760004, 1'b0, 1'b1, 16'hC0DE, 1'b1, 1'b1, "R6 io word write");
    run_op(22'o17760005, 1'b1, 1'b1, 16'h883C, 1'b1, 1'b1, "R5 io byte write odd");
    run_op(22'o17760004, 1'b0, 1'b0, 16'h0000, 1'b1, 1'b1, "R5 io readback after odd");
    run_op(22'o17760004, 1'b1, 1'b1, 16'h4471, 1'b1, 1'b1, "R5 io byte write even");
    run_op(22'o17760004, 1'b1, 1'b0, 16'h0000, 1'b1, 1'b1, "R3 io byte read even");

    // Odd word addresses
    run_op(22'o001001, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, "R7 odd word read memory");
    run_op(22'o17760001, 1'b0, 1'b1, 16'h1234, 1'b1, 1'b1, "R7 odd word write io");
    mem_lat = 0;
    run_op(22'o003000, 1'b0, 1'b1, 16'h2468, 1'b0, 1'b0, "R8 write right after error");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule